// File: doc/BRIEF.md
# MMC Host Register Frontend

This block is the memory-mapped control face of a simple MMC/SD host controller. Software programs a 32-bit argument and then writes a packed command word. That write is the trigger: a three-state sequencer hands the command to a downstream command engine over a valid/ready handshake, then waits for the engine to return the response. A short response lands in response word 0. A 136-bit response is spread over four words, lowest bits first. The block also holds the transfer buffer base address and the block length and block count for a data engine. Both counts are stored as value minus one in 11-bit fields.

Three events feed a write-one-to-clear interrupt status: command completion, data completion and a change of card state. Each event can be enabled on its own, and the interrupt line is a level. The card-inserted and write-protect inputs are asynchronous. They pass through a two-stage synchronizer, can be read back, and raise the card-change event when either one toggles.

Sequencer states and transitions: `ST_IDLE` moves to `ST_ISSUE` on LAUNCH, which is an accepted write to the command register. `ST_ISSUE` moves to `ST_WAIT` on HANDOFF, when `cmd_ready` is seen high. `ST_WAIT` moves to `ST_IDLE` on FINISH, when `rsp_valid` is seen high.

Top module: `mmc_regfront`

## Requirements
- R1: After reset, every register reads zero, `irq` and `cmd_valid` are low, and `cmd_word`, `buf_base`, `blk_len_m1` and `blk_cnt_m1` are zero.
- R2: The register map is as follows, with reads combinational from `rd_addr`:
  - 0x04: interrupt enable, bits 2:0.
  - 0x08: buffer base address, 32 bits, driven on `buf_base`.
  - 0x10: argument, 32 bits.
  - Any offset not listed in R2, R4, R5, R9, R10 or R12 reads zero, and a write to it changes nothing.
- R3: A write to offset 0x0C in `ST_IDLE` raises `cmd_valid` from the next cycle. At the same time `cmd_word` shows the stored command and `cmd_arg` shows the argument held at launch. All three stay stable until the cycle in which `cmd_ready` is high.
- R4: Only the defined command fields are stored:
  - opcode, bits 5:0
  - open-drain, bit 6
  - response type, bits 9:8 (0 none, 1 short, 2 long, 3 OCR-style short)
  - busy, bit 11
  - class, bits 13:12
  - read direction, bit 15

  All other bits read back as zero at 0x0C and on `cmd_word`.
- R5: When a response is accepted in `ST_WAIT`, the stored response type decides what is written:
  - Type 2 writes all four words: 0x14 gets bits 31:0, 0x18 gets 63:32, 0x1C gets 95:64 and 0x20 gets 127:96 of `rsp_data`.
  - Types 1 and 3 write only 0x14, from `rsp_data[31:0]`.
  - Type 0 leaves all four words unchanged.
- R6: Accepting a response returns the sequencer to `ST_IDLE` and sets interrupt status bit 0 at the same clock edge.
- R7: A write to 0x0C while a command is outstanding (`ST_ISSUE` or `ST_WAIT`) is ignored. Bit 31 of the card state register (0x2C) reads 1 from the launch edge until the response is accepted.
- R8: A one-cycle pulse on `data_done` sets interrupt status bit 1.
- R9: The card state register 0x2C shows the synchronized inputs: bit 0 is inserted and bit 1 is write-protected. A change on either input is visible two clocks later. One clock after that, interrupt status bit 2 is set.
- R10: The interrupt status register (0x00) is write-one-to-clear. A bit written as 0 is kept, and a set event in the same cycle as a clear leaves the bit set.
- R11: `irq` is high exactly while the bitwise AND of interrupt status and interrupt enable is nonzero.
- R12: Block length (0x24) and block count (0x28) each store 11 bits, drive `blk_len_m1` and `blk_cnt_m1`, and read back zero above bit 10. `data_phase` is high unless both fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Byte offset of the read |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Level interrupt |
| cmd_valid | output | 1 | Command request valid |
| cmd_ready | input | 1 | Command engine accepts |
| cmd_word | output | 16 | Packed command fields |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response returned by engine |
| rsp_data | input | 128 | Response bits, bit 0 lowest |
| buf_base | output | 32 | Transfer buffer base |
| blk_len_m1 | output | 11 | Block length minus one |
| blk_cnt_m1 | output | 11 | Block count minus one |
| data_phase | output | 1 | A data phase is programmed |
| data_done | input | 1 | Data engine finished pulse |
| card_in_async | input | 1 | Card inserted, asynchronous |
| card_wp_async | input | 1 | Write protect, asynchronous |

## Verification
Commands are issued with each of the four response types, so that the long path, the two short paths and the no-response path can be distinguished in the response words. The handshake is run with `cmd_ready` held low for several cycles, which separates a held request from a one-cycle pulse. A second command write is aimed at the outstanding window, and the bench checks that it is dropped. Status clears are tried alone and in the same cycle as a set event, which tells set-priority apart from clear-priority. The card inputs are toggled to measure the synchronizer depth.

// File: rtl/mmc_rf_pkg.sv
package mmc_rf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    localparam int OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_ISTAT = 6'h00;
    localparam logic [OFS_W-1:0] OFS_IEN   = 6'h04;
    localparam logic [OFS_W-1:0] OFS_BUF   = 6'h08;
    localparam logic [OFS_W-1:0] OFS_CMD   = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_ARG   = 6'h10;
    localparam logic [OFS_W-1:0] OFS_RSP0  = 6'h14;
    localparam logic [OFS_W-1:0] OFS_BLEN  = 6'h24;
    localparam logic [OFS_W-1:0] OFS_BCNT  = 6'h28;
    localparam logic [OFS_W-1:0] OFS_CARD  = 6'h2C;

    localparam int CMD_W = 16;
    // opcode 5:0, open-drain 6, resp type 9:8, busy 11, class 13:12, read 15
    localparam logic [CMD_W-1:0] CMD_KEEP = 16'hBB7F;
    localparam int RTYPE_LO = 8;

    localparam logic [1:0] RT_NONE = 2'd0;
    localparam logic [1:0] RT_LONG = 2'd2;

    localparam int EV_CMD  = 0;
    localparam int EV_DATA = 1;
    localparam int EV_CARD = 2;
    localparam int EV_N    = 3;

endpackage

// File: rtl/mmc_rf_sync.sv
module mmc_rf_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o,
    output logic         change_o
);
    logic [STAGES-1:0][N-1:0] pipe_q;
    logic [N-1:0]             prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[0] <= '0;
        else        pipe_q[0] <= async_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pipe_q[STAGES-1];
    end

    assign sync_o   = pipe_q[STAGES-1];
    assign change_o = |(pipe_q[STAGES-1] ^ prev_q);
endmodule

// File: rtl/mmc_rf_irq.sv
module mmc_rf_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] sts_o,
    output logic         irq_o
);
    logic [N-1:0] sts_q;

    generate
        for (genvar b = 0; b < N; b++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n)        sts_q[b] <= 1'b0;
                else if (set_i[b]) sts_q[b] <= 1'b1;
                else if (clr_i[b]) sts_q[b] <= 1'b0;
            end
        end
    endgenerate

    assign sts_o = sts_q;
    assign irq_o = |(sts_q & en_i);
endmodule

// File: rtl/mmc_rf_seq.sv
module mmc_rf_seq
    import mmc_rf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic [CMD_W-1:0] word_i,
    input  logic [DW-1:0]    arg_i,
    input  logic             cmd_ready,
    input  logic             rsp_valid,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_word,
    output logic [DW-1:0]    cmd_arg,
    output logic             busy_o,
    output logic             take_o,
    output logic [1:0]       rtype_o
);
    seq_state_e       state_q, state_d;
    logic             accept;
    logic [CMD_W-1:0] word_q;
    logic [DW-1:0]    arg_q;

    assign accept = launch_i && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch_i)  state_d = ST_ISSUE;
            ST_ISSUE: if (cmd_ready) state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_valid = 1'b0;
        busy_o    = 1'b0;
        take_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin
                cmd_valid = 1'b1;
                busy_o    = 1'b1;
            end
            ST_WAIT: begin
                busy_o = 1'b1;
                take_o = rsp_valid;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            arg_q  <= '0;
        end else if (accept) begin
            word_q <= word_i & CMD_KEEP;
            arg_q  <= arg_i;
        end
    end

    assign cmd_word = word_q;
    assign cmd_arg  = arg_q;
    assign rtype_o  = word_q[RTYPE_LO +: 2];
endmodule

// File: rtl/mmc_regfront.sv
module mmc_regfront
    import mmc_rf_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 6,
    parameter int LEN_W       = 11,
    parameter int RSP_WORDS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data,
    output logic                    irq,
    output logic                    cmd_valid,
    input  logic                    cmd_ready,
    output logic [CMD_W-1:0]        cmd_word,
    output logic [DW-1:0]           cmd_arg,
    input  logic                    rsp_valid,
    input  logic [RSP_WORDS*DW-1:0] rsp_data,
    output logic [DW-1:0]           buf_base,
    output logic [LEN_W-1:0]        blk_len_m1,
    output logic [LEN_W-1:0]        blk_cnt_m1,
    output logic                    data_phase,
    input  logic                    data_done,
    input  logic                    card_in_async,
    input  logic                    card_wp_async
);
    localparam int WSTEP = DW / 8;

    logic [EV_N-1:0]  ien_q, sts, set_v, clr_v;
    logic [DW-1:0]    base_q, arg_q;
    logic [LEN_W-1:0] len_q, cnt_q;
    logic [DW-1:0]    resp_q [RSP_WORDS];
    logic [1:0]       card_s;
    logic             card_chg, busy, take;
    logic [1:0]       rtype;

    function automatic logic hit(input logic [AW-1:0] ofs);
        return wr_en && (wr_addr == ofs);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            base_q <= '0;
            arg_q  <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (hit(OFS_IEN))  ien_q  <= wr_data[EV_N-1:0];
            if (hit(OFS_BUF))  base_q <= wr_data;
            if (hit(OFS_ARG))  arg_q  <= wr_data;
            if (hit(OFS_BLEN)) len_q  <= wr_data[LEN_W-1:0];
            if (hit(OFS_BCNT)) cnt_q  <= wr_data[LEN_W-1:0];
        end
    end

    mmc_rf_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (hit(OFS_CMD)),
        .word_i    (wr_data[CMD_W-1:0]),
        .arg_i     (arg_q),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .cmd_arg   (cmd_arg),
        .busy_o    (busy),
        .take_o    (take),
        .rtype_o   (rtype)
    );

    generate
        for (genvar i = 0; i < RSP_WORDS; i++) begin : g_rsp
            always_ff @(posedge clk) begin
                if (!rst_n)
                    resp_q[i] <= '0;
                else if (take && ((rtype == RT_LONG) || (i == 0 && rtype != RT_NONE)))
                    resp_q[i] <= rsp_data[i*DW +: DW];
            end
        end
    endgenerate

    mmc_rf_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_i  ({card_wp_async, card_in_async}),
        .sync_o   (card_s),
        .change_o (card_chg)
    );

    always_comb begin
        set_v          = '0;
        set_v[EV_CMD]  = take;
        set_v[EV_DATA] = data_done;
        set_v[EV_CARD] = card_chg;
        clr_v          = hit(OFS_ISTAT) ? wr_data[EV_N-1:0] : '0;
    end

    mmc_rf_irq #(.N(EV_N)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (clr_v),
        .en_i  (ien_q),
        .sts_o (sts),
        .irq_o (irq)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_ISTAT: rd_data[EV_N-1:0]  = sts;
            OFS_IEN:   rd_data[EV_N-1:0]  = ien_q;
            OFS_BUF:   rd_data            = base_q;
            OFS_CMD:   rd_data[CMD_W-1:0] = cmd_word;
            OFS_ARG:   rd_data            = arg_q;
            OFS_BLEN:  rd_data[LEN_W-1:0] = len_q;
            OFS_BCNT:  rd_data[LEN_W-1:0] = cnt_q;
            OFS_CARD:  begin
                rd_data[1:0]  = card_s;
                rd_data[DW-1] = busy;
            end
            default: ;
        endcase
        for (int i = 0; i < RSP_WORDS; i++)
            if (rd_addr == AW'(int'(OFS_RSP0) + i * WSTEP))
                rd_data = resp_q[i];
    end

    assign buf_base   = base_q;
    assign blk_len_m1 = len_q;
    assign blk_cnt_m1 = cnt_q;
    assign data_phase = (len_q != '0) || (cnt_q != '0);
endmodule

// File: rtl/mmc_regfront_chk.sv
module mmc_regfront_chk #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [15:0]   cmd_word,
    input logic          busy,
    input logic          rsp_valid,
    input logic [127:0]  rsp_data,
    input logic [2:0]    sts,
    input logic [2:0]    set_v,
    input logic [2:0]    ien,
    input logic          irq,
    input logic [DW-1:0] resp3,
    input logic [1:0]    rtype
);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word));

    assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_en && wr_addr == 6'h0C |=> $stable(cmd_word));

    assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[0]) |-> $past(busy && rsp_valid));

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == 6'h00 && wr_data[0] && !set_v[0] |=> !sts[0]);

    assert_setwins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_v[1] |=> sts[1]);

    assert_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != 3'b000) && (sts != 3'b000));

    assert_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cmd_valid && rsp_valid && rtype == 2'd2 |=> resp3 == $past(rsp_data[127:96]));
endmodule

bind mmc_regfront mmc_regfront_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_word  (cmd_word),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .sts       (sts),
    .set_v     (set_v),
    .ien       (ien_q),
    .irq       (irq),
    .resp3     (resp_q[3]),
    .rtype     (rtype)
);

// File: tb/sim_mmc_regfront.sv
module sim_mmc_regfront;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [5:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         irq, cmd_valid, data_phase;
    logic         cmd_ready = 1'b0;
    logic [15:0]  cmd_word;
    logic [31:0]  cmd_arg, buf_base;
    logic         rsp_valid = 1'b0;
    logic [127:0] rsp_data = '0;
    logic [10:0]  blk_len_m1, blk_cnt_m1;
    logic         data_done = 1'b0;
    logic         card_in_async = 1'b0, card_wp_async = 1'b0;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    int          m_state = 0;
    logic [2:0]  m_sts = 0, m_en = 0;
    logic [31:0] m_base = 0, m_arg = 0, m_la = 0;
    logic [15:0] m_lw = 0;
    logic [31:0] m_rsp [4] = '{default: 0};
    logic [10:0] m_len = 0, m_cnt = 0;
    logic [1:0]  m_s1 = 0, m_s2 = 0, m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmc_regfront u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .buf_base(buf_base),
        .blk_len_m1(blk_len_m1), .blk_cnt_m1(blk_cnt_m1), .data_phase(data_phase),
        .data_done(data_done), .card_in_async(card_in_async), .card_wp_async(card_wp_async)
    );

    task automatic model_step();
        logic [2:0]  setv, clrv;
        bit          launch, take;
        logic [1:0]  rt;
        launch = wr_en && wr_addr == 6'h0C && m_state == 0;
        take   = m_state == 2 && rsp_valid;
        setv   = {m_s2 != m_prev, data_done, take};
        clrv   = (wr_en && wr_addr == 6'h00) ? wr_data[2:0] : 3'b0;
        rt     = m_lw[9:8];
        if (take) begin
            if (rt == 2) for (int i = 0; i < 4; i++) m_rsp[i] = rsp_data[i*32 +: 32];
            else if (rt != 0) m_rsp[0] = rsp_data[31:0];
        end
        m_sts = (m_sts & ~clrv) | setv;
        if (launch) begin
            m_lw = wr_data[15:0] & 16'hBB7F;
            m_la = m_arg;
        end
        if (wr_en) begin
            case (wr_addr)
                6'h04: m_en   = wr_data[2:0];
                6'h08: m_base = wr_data;
                6'h10: m_arg  = wr_data;
                6'h24: m_len  = wr_data[10:0];
                6'h28: m_cnt  = wr_data[10:0];
                default: ;
            endcase
        end
        if (m_state == 0 && launch)         m_state = 1;
        else if (m_state == 1 && cmd_ready) m_state = 2;
        else if (take)                      m_state = 0;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = {card_wp_async, card_in_async};
    endtask

    function automatic logic [31:0] m_read(input logic [5:0] a);
        case (a)
            6'h00: return {29'b0, m_sts};
            6'h04: return {29'b0, m_en};
            6'h08: return m_base;
            6'h0C: return {16'b0, m_lw};
            6'h10: return m_arg;
            6'h14: return m_rsp[0];
            6'h18: return m_rsp[1];
            6'h1C: return m_rsp[2];
            6'h20: return m_rsp[3];
            6'h24: return {21'b0, m_len};
            6'h28: return {21'b0, m_cnt};
            6'h2C: return {m_state != 0, 29'b0, m_s2};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rtag(input logic [5:0] a);
        case (a)
            6'h00: return "R10";
            6'h0C: return "R4";
            6'h14, 6'h18, 6'h1C, 6'h20: return "R5";
            6'h24, 6'h28: return "R12";
            6'h2C: return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        cmp("R3 cmd_valid", {31'b0, cmd_valid}, {31'b0, m_state == 1});
        cmp("R3 cmd_word",  {16'b0, cmd_word}, {16'b0, m_lw});
        cmp("R3 cmd_arg",   cmd_arg, m_la);
        cmp("R11 irq",      {31'b0, irq}, {31'b0, |(m_sts & m_en)});
        cmp("R12 data_phase", {31'b0, data_phase}, {31'b0, (m_len != 0) || (m_cnt != 0)});
        cmp("R2 buf_base",  buf_base, m_base);
        cmp("R12 blk_len",  {21'b0, blk_len_m1}, {21'b0, m_len});
        cmp("R12 blk_cnt",  {21'b0, blk_cnt_m1}, {21'b0, m_cnt});
        cmp({rtag(rd_addr), " rd_data"}, rd_data, m_read(rd_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        compare_all();
        wr_en     = 1'b0;
        data_done = 1'b0;
        rsp_valid = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic rd_sweep();
        for (int a = 0; a <= 'h30; a += 4) begin
            rd_addr = 6'(a);
            tick();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_sweep();
        // R2 R12: plain registers
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h08, 32'h8000_1234);
        wr(6'h10, 32'hCAFE_0001);
        wr(6'h24, 32'hFFFF_F9FF);
        wr(6'h28, 32'h0000_0003);
        wr(6'h34, 32'hFFFF_FFFF);
        rd_sweep();
        // R3 R4 R7: long command, ready held low, second write while busy
        rd_addr = 6'h2C;
        wr(6'h0C, 32'hABCD_F6C2);
        tick(); tick();
        wr(6'h10, 32'h0000_BEEF);
        wr(6'h0C, 32'h0000_010D);
        cmd_ready = 1'b1; tick(); cmd_ready = 1'b0;
        wr(6'h0C, 32'h0000_0311);
        tick();
        // R5 R6: long response ordering
        rsp_data = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
        rsp_valid = 1'b1; tick();
        rd_addr = 6'h20; tick();
        rd_sweep();
        // R10: clear bit 0 alone
        rd_addr = 6'h00;
        wr(6'h00, 32'h0000_0001);
        // R8 R10: data done with a clear of bit 1 in the same cycle
        data_done = 1'b1; wr(6'h00, 32'h0000_0002);
        tick();
        wr(6'h00, 32'h0000_0000);
        wr(6'h00, 32'h0000_0002);
        // R5: short response type 1, then type 3, then type 0
        wr(6'h0C, 32'h0000_010D);
        cmd_ready = 1'b1; tick(); cmd_ready = 1'b0;
        rsp_data = 128'h9999_9999_8888_8888_7777_7777_5555_5555;
        rsp_valid = 1'b1; tick();
        rd_sweep();
        wr(6'h0C, 32'h0000_0329);
        cmd_ready = 1'b1; tick(); cmd_ready = 1'b0;
        rsp_data = 128'h0;
        rsp_data[31:0] = 32'h00FF_8000;
        rsp_valid = 1'b1; tick();
        wr(6'h0C, 32'h0000_0000);
        cmd_ready = 1'b1; tick(); cmd_ready = 1'b0;
        rsp_data = {4{32'hDEAD_BEEF}};
        rsp_valid = 1'b1; tick();
        rd_sweep();
        // R9: card inserted, then write protect
        wr(6'h00, 32'h0000_0007);
        rd_addr = 6'h2C;
        card_in_async = 1'b1;
        repeat (4) tick();
        rd_addr = 6'h00;
        wr(6'h00, 32'h0000_0004);
        card_wp_async = 1'b1;
        repeat (4) tick();
        // R11: disable and re-enable interrupts
        wr(6'h04, 32'h0000_0000);
        wr(6'h04, 32'h0000_0004);
        // R12: no data phase
        wr(6'h24, 32'h0);
        wr(6'h28, 32'h0);
        rd_sweep();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule